// File: doc/BRIEF.md
# Virtual Channel Reservation Unit

This block owns the output virtual channel reservation table of a router. Each cycle every input port may present one flit that upstream selection has already picked: a 2-bit kind field, the input virtual channel it came from, and the output port that route computation chose. The unit decides for each of these flits whether it moves forward or stays put in its input virtual channel for a later retry. For a forwarded flit it reports the output virtual channel it uses.

The table holds one entry per output virtual channel of every output port. Each entry has a busy flag and an owner tag naming the input port and input virtual channel that hold it. A packet's opening flit claims a free entry on its output. Its middle flits pass only on the entry their own input channel holds. Its closing flit passes the same way and frees the entry. A flit that forms a whole packet on its own passes without touching the table.

All decisions are registered, and the table is updated at the same clock edge. A decision made in one cycle is therefore seen by the flits of the next.

Top module: `vcr_unit`

## Requirements
- R1: While reset is asserted and at the first edge after reset, `fwd` and `hold` are all zero, and every table entry reads busy 0 and owner 0.
- R2: The kind of a flit is taken from its two most significant bits: 00 single-flit packet, 01 opening flit, 10 middle flit, 11 closing flit. Lane n's decision for a flit presented in one cycle appears on `fwd`/`hold`/`fwd_vc`/`fwd_flit` after the next rising edge. The table outputs change at that same edge.
- R3: A single-flit packet with a legal output is always forwarded with `fwd_vc` 0 and leaves the table unchanged.
- R4: An opening flit is forwarded only if its output port has an entry that was not busy at the start of the cycle. It then sets that entry busy with owner {lane number (upper 3 bits), input VC (lower 2 bits)}.
- R5: Among free entries of an output port, an opening flit takes the lowest-numbered virtual channel.
- R6: Opening flits from several lanes to the same output in one cycle are served in ascending lane order, each getting a distinct channel. Lanes left without a free channel are held.
- R7: A middle flit is forwarded only if an entry of its output port is busy with owner equal to its own {lane, input VC}. It leaves on that channel and does not change the table. Otherwise it is held.
- R8: A closing flit passes under the same rule as a middle flit. When forwarded, its entry reads busy 0 and owner 0 after the same edge.
- R9: Every valid input flit yields exactly one of `fwd` or `hold`. A held flit changes nothing in the table, and its `fwd_flit` lane reads zero. A forwarded flit appears unchanged on `fwd_flit`.
- R10: An opening flit claiming one entry and a closing flit freeing another entry in the same cycle both take effect at the same edge.
- R11: An entry freed by a closing flit is not available to an opening flit in the same cycle. It is available from the next cycle on.
- R12: A flit whose output port number is 5 or above (not an existing port) is held, whatever its kind, and changes no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | One flit present per input lane |
| in_flit | input | 90 | Lane flits, 18 bits each, kind in bits 17:16 of each |
| in_vc | input | 10 | Input virtual channel of each lane, 2 bits each |
| in_dest | input | 15 | Requested output port of each lane, 3 bits each |
| fwd | output | 5 | Lane flit was forwarded |
| hold | output | 5 | Lane flit was pushed back for a retry |
| fwd_vc | output | 10 | Output virtual channel used by each forwarded flit |
| fwd_flit | output | 90 | Forwarded flit per lane, zero when not forwarded |
| tbl_busy | output | 20 | Busy flag per entry, entry = port*4 + vc |
| tbl_owner | output | 100 | Owner tag per entry, 5 bits each |

## Verification
Single-flit packets are swept over every lane and every output to show that they pass without touching the table. An opening flit is swept from every lane to every output in turn. This shows the lowest-first choice and, with the fifth claimant, that a full output holds. Tails then empty each output again. Directed cycles show several things. Lanes contend on one output in the same cycle. Middle flits come from the owner, a foreign lane and the owner's lane with the wrong input channel, so ownership matching is separated from mere occupancy. A closing flit meets an opening flit on the same output and on another output, which tells the no-reuse rule apart from simultaneous claim and release. Last comes a long stream of mixed kinds with concentrated and illegal destinations, checked against an arithmetic model of the table.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        K_SOLO = 2'b00,
        K_HEAD = 2'b01,
        K_BODY = 2'b10,
        K_TAIL = 2'b11
    } kind_e;

endpackage

// File: rtl/vcr_owner_match.sv
// Finds the output VC of one output port that is held by a given owner tag.
module vcr_owner_match #(
    parameter  int NPORT = 5,
    parameter  int NVC   = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VCW   = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int OWNW  = PW + VCW,
    localparam int NENT  = NPORT * NVC,
    localparam int EW    = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic [NENT-1:0]      busy,
    input  logic [NENT*OWNW-1:0] owner,
    input  logic [PW-1:0]        dest,
    input  logic [OWNW-1:0]      me,
    output logic                 hit,
    output logic [VCW-1:0]       hit_vc
);

    logic [EW-1:0] idx;

    always_comb begin
        hit    = 1'b0;
        hit_vc = '0;
        idx    = '0;
        if (int'(dest) < NPORT) begin
            for (int v = 0; v < NVC; v++) begin
                idx = EW'(int'(dest) * NVC + v);
                if (!hit && busy[idx] && (owner[int'(idx) * OWNW +: OWNW] == me)) begin
                    hit    = 1'b1;
                    hit_vc = VCW'(v);
                end
            end
        end
    end

endmodule

// File: rtl/vcr_alloc.sv
// Hands out free output VCs to opening flits, lanes in ascending order,
// lowest free VC first. Freedom is judged on the registered table only.
module vcr_alloc #(
    parameter  int NPORT = 5,
    parameter  int NVC   = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VCW   = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int NENT  = NPORT * NVC,
    localparam int EW    = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic [NPORT-1:0]     want,
    input  logic [NPORT*PW-1:0]  dest,
    input  logic [NENT-1:0]      busy,
    output logic [NPORT-1:0]     grant,
    output logic [NPORT*VCW-1:0] gvc,
    output logic [NENT-1:0]      claim
);

    logic [EW-1:0] idx;

    always_comb begin
        grant = '0;
        gvc   = '0;
        claim = '0;
        idx   = '0;
        for (int ln = 0; ln < NPORT; ln++) begin
            if (want[ln]) begin
                for (int v = 0; v < NVC; v++) begin
                    idx = EW'(int'(dest[ln*PW +: PW]) * NVC + v);
                    if (!grant[ln] && !busy[idx] && !claim[idx]) begin
                        grant[ln]           = 1'b1;
                        gvc[ln*VCW +: VCW]  = VCW'(v);
                        claim[idx]          = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vcr_table.sv
// Registered reservation table: busy flag and owner tag per output VC.
module vcr_table #(
    parameter  int NPORT = 5,
    parameter  int NVC   = 4,
    parameter  int OWNW  = 5,
    localparam int NENT  = NPORT * NVC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NENT-1:0]      set,
    input  logic [NENT-1:0]      clr,
    input  logic [NENT*OWNW-1:0] wr_owner,
    output logic [NENT-1:0]      busy,
    output logic [NENT*OWNW-1:0] owner
);

    typedef struct packed {
        logic [NENT-1:0]      busy;
        logic [NENT*OWNW-1:0] owner;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int k = 0; k < NENT; k++) begin
            if (clr[k]) begin
                tbl_d.busy[k]                = 1'b0;
                tbl_d.owner[k*OWNW +: OWNW]  = '0;
            end
            if (set[k]) begin
                tbl_d.busy[k]                = 1'b1;
                tbl_d.owner[k*OWNW +: OWNW]  = wr_owner[k*OWNW +: OWNW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign busy  = tbl_q.busy;
    assign owner = tbl_q.owner;

    // R4: a claim may only land on an entry that is currently free
    p_claim_on_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set & tbl_q.busy) == '0);

    // R8: a release may only hit an entry that is currently held
    p_free_on_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr & ~tbl_q.busy) == '0);

    // R11: one entry is never claimed and released at the same edge
    p_no_claim_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set & clr) == '0);

endmodule

// File: rtl/vcr_unit.sv
module vcr_unit
    import vcr_pkg::*;
#(
    parameter  int NPORT  = 5,
    parameter  int NVC    = 4,
    parameter  int FLIT_W = 18,
    localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VCW    = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int OWNW   = PW + VCW,
    localparam int NENT   = NPORT * NVC,
    localparam int EW     = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         in_valid,
    input  logic [NPORT*FLIT_W-1:0]  in_flit,
    input  logic [NPORT*VCW-1:0]     in_vc,
    input  logic [NPORT*PW-1:0]      in_dest,
    output logic [NPORT-1:0]         fwd,
    output logic [NPORT-1:0]         hold,
    output logic [NPORT*VCW-1:0]     fwd_vc,
    output logic [NPORT*FLIT_W-1:0]  fwd_flit,
    output logic [NENT-1:0]          tbl_busy,
    output logic [NENT*OWNW-1:0]     tbl_owner
);

    typedef struct packed {
        logic [NPORT-1:0]        fwd;
        logic [NPORT-1:0]        hold;
        logic [NPORT*VCW-1:0]    vc;
        logic [NPORT*FLIT_W-1:0] flit;
    } res_t;

    res_t res_d, res_q;

    logic [NPORT*KIND_W-1:0] kind_all;
    logic [NPORT*OWNW-1:0]   me_all;
    logic [NPORT-1:0]        dest_ok;
    logic [NPORT-1:0]        want;
    logic [NPORT-1:0]        grant;
    logic [NPORT*VCW-1:0]    gvc;
    logic [NPORT-1:0]        hit;
    logic [NPORT*VCW-1:0]    hit_vc;
    logic [NENT-1:0]         claim;
    logic [NENT-1:0]         drop_m;
    logic [NENT*OWNW-1:0]    wr_owner;
    logic [NENT-1:0]         busy;
    logic [NENT*OWNW-1:0]    owner;
    logic [EW-1:0]           ent;
    kind_e                   kind_c;

    // per-lane decode and ownership lookup
    for (genvar g = 0; g < NPORT; g++) begin : g_lane
        assign kind_all[g*KIND_W +: KIND_W] = in_flit[g*FLIT_W + FLIT_W - 1 -: KIND_W];
        assign dest_ok[g] = int'(in_dest[g*PW +: PW]) < NPORT;
        assign me_all[g*OWNW +: OWNW] = {PW'(g), in_vc[g*VCW +: VCW]};
        assign want[g] = in_valid[g] && dest_ok[g]
                         && (kind_all[g*KIND_W +: KIND_W] == K_HEAD);

        vcr_owner_match #(
            .NPORT (NPORT),
            .NVC   (NVC)
        ) u_match (
            .busy   (busy),
            .owner  (owner),
            .dest   (in_dest[g*PW +: PW]),
            .me     (me_all[g*OWNW +: OWNW]),
            .hit    (hit[g]),
            .hit_vc (hit_vc[g*VCW +: VCW])
        );
    end

    vcr_alloc #(
        .NPORT (NPORT),
        .NVC   (NVC)
    ) u_alloc (
        .want  (want),
        .dest  (in_dest),
        .busy  (busy),
        .grant (grant),
        .gvc   (gvc),
        .claim (claim)
    );

    vcr_table #(
        .NPORT (NPORT),
        .NVC   (NVC),
        .OWNW  (OWNW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (claim),
        .clr      (drop_m),
        .wr_owner (wr_owner),
        .busy     (busy),
        .owner    (owner)
    );

    // decision per lane
    always_comb begin
        res_d    = '0;
        drop_m   = '0;
        wr_owner = '0;
        ent      = '0;
        kind_c   = K_SOLO;
        for (int ln = 0; ln < NPORT; ln++) begin
            kind_c = kind_e'(kind_all[ln*KIND_W +: KIND_W]);
            if (in_valid[ln]) begin
                if (dest_ok[ln]) begin
                    case (kind_c)
                        K_SOLO: begin
                            res_d.fwd[ln] = 1'b1;
                        end
                        K_HEAD: begin
                            if (grant[ln]) begin
                                res_d.fwd[ln]             = 1'b1;
                                res_d.vc[ln*VCW +: VCW]   = gvc[ln*VCW +: VCW];
                                ent = EW'(int'(in_dest[ln*PW +: PW]) * NVC
                                          + int'(gvc[ln*VCW +: VCW]));
                                wr_owner[int'(ent)*OWNW +: OWNW] = me_all[ln*OWNW +: OWNW];
                            end
                        end
                        K_BODY, K_TAIL: begin
                            if (hit[ln]) begin
                                res_d.fwd[ln]             = 1'b1;
                                res_d.vc[ln*VCW +: VCW]   = hit_vc[ln*VCW +: VCW];
                                if (kind_c == K_TAIL) begin
                                    ent = EW'(int'(in_dest[ln*PW +: PW]) * NVC
                                              + int'(hit_vc[ln*VCW +: VCW]));
                                    drop_m[ent] = 1'b1;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                res_d.hold[ln] = !res_d.fwd[ln];
                if (res_d.fwd[ln]) begin
                    res_d.flit[ln*FLIT_W +: FLIT_W] = in_flit[ln*FLIT_W +: FLIT_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign fwd       = res_q.fwd;
    assign hold      = res_q.hold;
    assign fwd_vc    = res_q.vc;
    assign fwd_flit  = res_q.flit;
    assign tbl_busy  = busy;
    assign tbl_owner = owner;

    // ---------------------------------------------------------------
    // Assertion support: inputs and table of the decided cycle
    // ---------------------------------------------------------------
    logic                    live_q;
    logic [NPORT-1:0]        valid_q;
    logic [NPORT*KIND_W-1:0] kind_q;
    logic [NPORT*PW-1:0]     dest_q;
    logic [NPORT*OWNW-1:0]   me_q;
    logic [NENT-1:0]         busy_prev_q;
    logic [NPORT-1:0]        moves_tbl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q      <= 1'b0;
            valid_q     <= '0;
            kind_q      <= '0;
            dest_q      <= '0;
            me_q        <= '0;
            busy_prev_q <= '0;
        end else begin
            live_q      <= 1'b1;
            valid_q     <= in_valid;
            kind_q      <= kind_all;
            dest_q      <= in_dest;
            me_q        <= me_all;
            busy_prev_q <= busy;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        logic [EW-1:0] ent_c;
        assign ent_c = EW'(int'(dest_q[g*PW +: PW]) * NVC + int'(fwd_vc[g*VCW +: VCW]));
        // header (01) and tail (11) share kind bit 0
        assign moves_tbl[g] = fwd[g] && kind_q[g*KIND_W];

        // R4: a forwarded opening flit found its entry free and now owns it
        p_head_claims_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && fwd[g] && (kind_q[g*KIND_W +: KIND_W] == K_HEAD)
            |-> !busy_prev_q[ent_c] && busy[ent_c]
                && (owner[int'(ent_c)*OWNW +: OWNW] == me_q[g*OWNW +: OWNW]));

        // R7: a forwarded middle flit rides an entry its own channel holds
        p_body_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && fwd[g] && (kind_q[g*KIND_W +: KIND_W] == K_BODY)
            |-> busy_prev_q[ent_c] && busy[ent_c]
                && (owner[int'(ent_c)*OWNW +: OWNW] == me_q[g*OWNW +: OWNW]));

        // R8: a forwarded closing flit left its held entry free
        p_tail_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && fwd[g] && (kind_q[g*KIND_W +: KIND_W] == K_TAIL)
            |-> busy_prev_q[ent_c] && !busy[ent_c]);

        // R3: a single-flit packet reports VC 0
        p_solo_vc0_r3: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && fwd[g] && (kind_q[g*KIND_W +: KIND_W] == K_SOLO)
            |-> fwd_vc[g*VCW +: VCW] == '0);

        // R12: a flit to a port that does not exist is always held
        p_bad_dest_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && valid_q[g] && (int'(dest_q[g*PW +: PW]) >= NPORT)
            |-> hold[g] && !fwd[g]);
    end

    // R9: each valid flit gets exactly one outcome, idle lanes get none
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((fwd & hold) == '0) && ((fwd | hold) == valid_q));

    // R3: without a forwarded opening or closing flit the busy flags stay put
    p_table_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && (moves_tbl == '0) |-> busy == busy_prev_q);

endmodule

// File: tb/vcr_unit_test.sv
module vcr_unit_test;

    localparam int NP = 5;
    localparam int NV = 4;
    localparam int FW = 18;
    localparam int PW = 3;
    localparam int VW = 2;
    localparam int OW = 5;
    localparam int NE = NP * NV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NP-1:0]    in_valid = '0;
    logic [NP*FW-1:0] in_flit = '0;
    logic [NP*VW-1:0] in_vc = '0;
    logic [NP*PW-1:0] in_dest = '0;
    logic [NP-1:0]    fwd, hold;
    logic [NP*VW-1:0] fwd_vc;
    logic [NP*FW-1:0] fwd_flit;
    logic [NE-1:0]    tbl_busy;
    logic [NE*OW-1:0] tbl_owner;

    vcr_unit #(.NPORT(NP), .NVC(NV), .FLIT_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_vc(in_vc), .in_dest(in_dest), .fwd(fwd), .hold(hold),
        .fwd_vc(fwd_vc), .fwd_flit(fwd_flit), .tbl_busy(tbl_busy),
        .tbl_owner(tbl_owner)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // lane stimulus
    logic        lv[NP];
    logic [1:0]  lk[NP];
    logic [1:0]  lvc[NP];
    logic [2:0]  ld[NP];
    logic [15:0] lp[NP];
    // table model
    logic          mb[NE];
    logic [OW-1:0] mo[NE];
    logic [31:0]   rng = 32'h2545_f491;

    task automatic chk(input string tag, input string what, input int idx,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s[%0d]: actual %h expected %h", tag, what, idx, act, exp);
        end
    endtask

    task automatic idle_lanes();
        for (int i = 0; i < NP; i++) begin
            lv[i] = 1'b0; lk[i] = 2'b00; lvc[i] = 2'd0; ld[i] = 3'd0; lp[i] = 16'h0;
        end
    endtask

    task automatic put(input int ln, input logic [1:0] k, input logic [1:0] vc,
                       input logic [2:0] d, input logic [15:0] p);
        lv[ln] = 1'b1; lk[ln] = k; lvc[ln] = vc; ld[ln] = d; lp[ln] = p;
    endtask

    // apply lanes at a falling edge, predict, sample at the next falling edge
    task automatic step(input string tag);
        logic          ef[NP];
        logic [1:0]    ev[NP];
        logic          tk[NE];
        logic          cl[NE];
        logic [OW-1:0] no[NE];
        int e;
        for (int i = 0; i < NE; i++) begin tk[i] = 1'b0; cl[i] = 1'b0; no[i] = '0; end
        for (int ln = 0; ln < NP; ln++) begin
            in_valid[ln]          = lv[ln];
            in_flit[ln*FW +: FW]  = {lk[ln], lp[ln]};
            in_vc[ln*VW +: VW]    = lvc[ln];
            in_dest[ln*PW +: PW]  = ld[ln];
            ef[ln] = 1'b0; ev[ln] = 2'd0;
            if (lv[ln] && int'(ld[ln]) < NP) begin
                case (lk[ln])
                    2'b00: ef[ln] = 1'b1;
                    2'b01: for (int v = 0; v < NV; v++) begin
                        e = int'(ld[ln]) * NV + v;
                        if (!ef[ln] && !mb[e] && !tk[e]) begin
                            ef[ln] = 1'b1; ev[ln] = 2'(v); tk[e] = 1'b1;
                            no[e] = {3'(ln), lvc[ln]};
                        end
                    end
                    default: for (int v = 0; v < NV; v++) begin
                        e = int'(ld[ln]) * NV + v;
                        if (!ef[ln] && mb[e] && mo[e] == {3'(ln), lvc[ln]}) begin
                            ef[ln] = 1'b1; ev[ln] = 2'(v);
                            if (lk[ln] == 2'b11) cl[e] = 1'b1;
                        end
                    end
                endcase
            end
        end
        for (int i = 0; i < NE; i++) begin
            if (cl[i]) begin mb[i] = 1'b0; mo[i] = '0; end
            if (tk[i]) begin mb[i] = 1'b1; mo[i] = no[i]; end
        end
        @(posedge clk);
        @(negedge clk);
        for (int ln = 0; ln < NP; ln++) begin
            chk(tag, "lane", ln,
                64'({fwd[ln], hold[ln], fwd_vc[ln*VW +: VW], fwd_flit[ln*FW +: FW]}),
                64'({ef[ln], lv[ln] && !ef[ln], ef[ln] ? ev[ln] : 2'd0,
                     ef[ln] ? {lk[ln], lp[ln]} : 18'd0}));
        end
        for (int i = 0; i < NE; i++) begin
            chk(tag, "entry", i, 64'({tbl_busy[i], tbl_owner[i*OW +: OW]}),
                64'({mb[i], mo[i]}));
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        for (int i = 0; i < NE; i++) begin mb[i] = 1'b0; mo[i] = '0; end
        idle_lanes();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", "fwd", 0, 64'(fwd), 64'(0));
        chk("R1 reset", "hold", 0, 64'(hold), 64'(0));
        chk("R1 reset", "busy", 0, 64'(tbl_busy), 64'(0));
        chk("R1 reset", "owner_or", 0, 64'(|tbl_owner), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", "fwd", 0, 64'(fwd | hold), 64'(0));
        chk("R1 after reset", "busy", 0, 64'(tbl_busy), 64'(0));

        // R3: single-flit packets on every lane to every output
        for (int d = 0; d < NP; d++) begin
            idle_lanes();
            for (int ln = 0; ln < NP; ln++) put(ln, 2'b00, 2'(ln), 3'(d), 16'(16'hA000 + ln*16 + d));
            step("R3 R2 solo sweep");
        end

        // R4 R5: opening flit from each lane to each output, one per cycle
        for (int d = 0; d < NP; d++) begin
            for (int ln = 0; ln < NP; ln++) begin
                idle_lanes();
                put(ln, 2'b01, 2'(ln % NV), 3'(d), 16'(16'hB000 + ln*16 + d));
                step("R4 R5 header sweep");
            end
            for (int ln = 0; ln < NV; ln++) begin
                idle_lanes();
                put(ln, 2'b10, 2'(ln % NV), 3'(d), 16'(16'hC000 + ln));
                step("R7 body sweep");
                idle_lanes();
                put(ln, 2'b11, 2'(ln % NV), 3'(d), 16'(16'hD000 + ln));
                step("R8 tail sweep");
            end
        end

        // R6: all lanes open on output 1 at once
        idle_lanes();
        for (int ln = 0; ln < NP; ln++) put(ln, 2'b01, 2'(ln % NV), 3'd1, 16'(16'h6000 + ln));
        step("R6 R5 contention");

        // R7 R9: owner, foreign lane and wrong input VC
        idle_lanes();
        put(2, 2'b10, 2'd2, 3'd1, 16'h7002);
        put(4, 2'b10, 2'd0, 3'd1, 16'h7004);
        put(0, 2'b10, 2'd1, 3'd1, 16'h7000);
        step("R7 R9 ownership");

        // R11: tail frees vc1 of output 1 while a header asks for output 1
        idle_lanes();
        put(1, 2'b11, 2'd1, 3'd1, 16'h8001);
        put(4, 2'b01, 2'd3, 3'd1, 16'h8004);
        step("R11 no same-cycle reuse");
        idle_lanes();
        put(4, 2'b01, 2'd3, 3'd1, 16'h8104);
        step("R11 R5 reuse next cycle");

        // R10: release on output 1, claim on output 2, same cycle
        idle_lanes();
        put(3, 2'b11, 2'd3, 3'd1, 16'h9003);
        put(0, 2'b01, 2'd2, 3'd2, 16'h9000);
        step("R10 claim and release");

        // R12: nonexistent outputs
        for (int d = 5; d < 8; d++) begin
            idle_lanes();
            for (int ln = 0; ln < NP; ln++) put(ln, 2'(ln % 4), 2'(ln % NV), 3'(d), 16'(16'hE000 + ln));
            step("R12 illegal output");
        end

        // R2 R9: mixed traffic against the model
        for (int c = 0; c < 3000; c++) begin
            idle_lanes();
            for (int ln = 0; ln < NP; ln++) begin
                rng = nxt(rng);
                if (rng[0] | rng[1]) begin
                    put(ln, rng[3:2], rng[5:4],
                        (rng[8:6] == 3'd7) ? 3'd6 :
                        (rng[8:6] == 3'd6) ? 3'd2 : {2'b00, rng[9]},
                        rng[31:16]);
                end
            end
            step("R2 R9 mixed traffic");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule